// File: doc/BRIEF.md
# Bit-band alias bridge

This block is a bus slave that turns single-bit alias accesses into operations on ordinary target memory. Each alias window is 32 MB wide, and every 32-bit aligned word inside it stands for exactly one bit of a 1 MB target region. With the default parameters there are two windows. The alias window at 0x2200_0000 maps onto the memory at 0x2000_0000. The alias window at 0x4200_0000 maps onto the peripheral space at 0x4000_0000.

A requester issues a single transfer on the slave port. The transfer carries an address, a size of byte, halfword or word, and for writes a data value. An alias read fetches the addressed target unit and returns the chosen bit as 0 or 1. An alias write fetches the unit, forces the chosen bit to bit 0 of the write data and stores the unit back. The lock output stays asserted across both beats of that write, so no other master can slip in between them. Addresses outside every window, and the reserved size code, are refused with an error pulse.

Top module: `bitband_bridge`

## Requirements
- R1: An alias address hits a window when its bits [31:25] equal those of the window's alias base. The master address is the window's target base ORed with alias address bits [24:5], before alignment.
- R2: The size code is 0 for a byte, 1 for a halfword and 2 for a word. A halfword clears master address bit 0, and a word clears master address bits [1:0]. The master size output repeats the request's size code.
- R3: The bit index is taken from alias address bits [4:2] for a byte, [5:2] for a halfword and [6:2] for a word.
- R4: Master read data carries the unit right-justified, assembled little-endian from the target bytes. Its bits above the unit width are ignored. An alias read returns the selected bit in bit 0 of the slave read data, and bits [31:1] are zero.
- R5: An alias write sets the selected bit when write data bit 0 is 1 and clears it when bit 0 is 0. Every other bit of the unit is written back unchanged, and master write data above the unit width is zero.
- R6: An alias write makes exactly two master beats, a read followed by a write. The lock output is high through both beats, with no gap between them. An alias read makes one master read beat, with the lock output low.
- R7: Slave ready is a one-cycle pulse. It comes in the cycle after the last master beat's ready: the read beat for an alias read, and the write-back beat for an alias write.
- R8: A request that hits no window, or uses size code 3, makes no master beat. It answers with a one-cycle slave error pulse in the next cycle.
- R9: While reset is asserted and right after it, slave ready, slave error, master request and master lock are all low.
- R10: Master request stays high until master ready is seen, and the master address and write strobe do not change while the request waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_req | input | 1 | Slave request, held until ready or error |
| s_we | input | 1 | Slave write strobe |
| s_addr | input | 32 | Alias byte address |
| s_size | input | 2 | Access size code (0 byte, 1 halfword, 2 word) |
| s_wdata | input | 32 | Write data, only bit 0 used |
| s_rdata | output | 32 | Selected bit in bit 0 |
| s_ready | output | 1 | One-cycle completion pulse |
| s_err | output | 1 | One-cycle error pulse for unclaimed requests |
| m_req | output | 1 | Master request |
| m_we | output | 1 | Master write strobe |
| m_addr | output | 32 | Aligned target byte address |
| m_size | output | 2 | Target unit size code |
| m_wdata | output | 32 | Right-justified unit to store |
| m_lock | output | 1 | Keeps the read-modify-write indivisible |
| m_ready | input | 1 | Master beat completion |
| m_rdata | input | 32 | Right-justified unit read from the target |

## Verification
A wrong latched bit index or window choice shows up in the first master beat, at the master address. It also shows up one cycle after that beat, as a wrong read bit. A modify step that corrupts the unit is caught by the bench's shadow memory. That mismatch becomes visible on the very next read of any bit in the same unit. A sequencer that drops the lock, skips the write-back or answers too early shows up at the ports within a cycle or two. It appears as a lock gap, a missing second beat, or a ready pulse without a preceding master ready.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int AW = 32;
    localparam int DW = 32;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_RESP,
        ST_ERR
    } state_e;

    typedef struct packed {
        state_e          state;
        logic            we;
        logic [1:0]      size;
        logic [AW-1:0]   tgt;
        logic [4:0]      idx;
        logic            set_bit;
        logic            rd_bit;
        logic [DW-1:0]   wunit;
    } regs_t;
endpackage

// File: rtl/bb_decode.sv
module bb_decode
    import bb_pkg::*;
#(
    parameter int                   NUM_WIN     = 2,
    parameter int                   WIN_BITS    = 25,
    parameter logic [NUM_WIN*32-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*32-1:0] TGT_BASES   = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output logic          hit,
    output logic [AW-1:0] tgt,
    output logic [4:0]    idx
);
    localparam int HI_BITS = AW - WIN_BITS;

    logic [NUM_WIN-1:0] hit_w;
    logic [AW-1:0]      tgt_w [NUM_WIN];
    logic [AW-1:0]      tgt_raw;
    logic               any_hit;
    logic [1:0]         unused_lsb;

    assign unused_lsb = addr[1:0];

    generate
        for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
            assign hit_w[i] = (addr[AW-1:WIN_BITS] == ALIAS_BASES[i*32+WIN_BITS +: HI_BITS]);
            assign tgt_w[i] = TGT_BASES[i*32 +: 32] | AW'(addr[WIN_BITS-1:5]);
        end
    endgenerate

    always_comb begin
        any_hit = 1'b0;
        tgt_raw = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hit_w[i] && !any_hit) begin
                any_hit = 1'b1;
                tgt_raw = tgt_w[i];
            end
        end
        hit = any_hit;
        case (size)
            SZ_BYTE: begin
                idx = {2'b00, addr[4:2]};
                tgt = tgt_raw;
            end
            SZ_HALF: begin
                idx = {1'b0, addr[5:2]};
                tgt = {tgt_raw[AW-1:1], 1'b0};
            end
            SZ_WORD: begin
                idx = addr[6:2];
                tgt = {tgt_raw[AW-1:2], 2'b00};
            end
            default: begin
                idx = '0;
                tgt = tgt_raw;
                hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bb_bitop.sv
module bb_bitop
    import bb_pkg::*;
(
    input  logic [DW-1:0] unit_raw,
    input  logic [1:0]    size,
    input  logic [4:0]    idx,
    input  logic          set_bit,
    output logic          bit_val,
    output logic [DW-1:0] new_unit
);
    logic [DW-1:0] wmask;
    logic [DW-1:0] unit;
    logic [DW-1:0] sel;

    always_comb begin
        case (size)
            SZ_BYTE: wmask = DW'(8'hFF);
            SZ_HALF: wmask = DW'(16'hFFFF);
            default: wmask = '1;
        endcase
        unit     = unit_raw & wmask;
        sel      = DW'(1) << idx;
        bit_val  = |(unit & sel);
        new_unit = set_bit ? (unit | sel) : (unit & ~sel);
    end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int                   NUM_WIN     = 2,
    parameter int                   WIN_BITS    = 25,
    parameter logic [NUM_WIN*32-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*32-1:0] TGT_BASES   = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_req,
    input  logic          s_we,
    input  logic [31:0]   s_addr,
    input  logic [1:0]    s_size,
    input  logic [31:0]   s_wdata,
    output logic [31:0]   s_rdata,
    output logic          s_ready,
    output logic          s_err,
    output logic          m_req,
    output logic          m_we,
    output logic [31:0]   m_addr,
    output logic [1:0]    m_size,
    output logic [31:0]   m_wdata,
    output logic          m_lock,
    input  logic          m_ready,
    input  logic [31:0]   m_rdata
);
    regs_t q, d;

    logic          dec_hit;
    logic [AW-1:0] dec_tgt;
    logic [4:0]    dec_idx;
    logic          op_bit;
    logic [DW-1:0] op_new;
    logic [30:0]   unused_wdata;

    assign unused_wdata = s_wdata[31:1];

    bb_decode #(
        .NUM_WIN     (NUM_WIN),
        .WIN_BITS    (WIN_BITS),
        .ALIAS_BASES (ALIAS_BASES),
        .TGT_BASES   (TGT_BASES)
    ) decode_i (
        .addr (s_addr),
        .size (s_size),
        .hit  (dec_hit),
        .tgt  (dec_tgt),
        .idx  (dec_idx)
    );

    bb_bitop bitop_i (
        .unit_raw (m_rdata),
        .size     (q.size),
        .idx      (q.idx),
        .set_bit  (q.set_bit),
        .bit_val  (op_bit),
        .new_unit (op_new)
    );

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (s_req) begin
                    d.we      = s_we;
                    d.size    = s_size;
                    d.tgt     = dec_tgt;
                    d.idx     = dec_idx;
                    d.set_bit = s_wdata[0];
                    d.state   = dec_hit ? ST_RD : ST_ERR;
                end
            end
            ST_RD: begin
                if (m_ready) begin
                    d.rd_bit = q.we ? 1'b0 : op_bit;
                    d.wunit  = op_new;
                    d.state  = q.we ? ST_WR : ST_RESP;
                end
            end
            ST_WR: begin
                if (m_ready) begin
                    d.state = ST_RESP;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, we: 1'b0, size: SZ_BYTE, tgt: '0, idx: '0,
                   set_bit: 1'b0, rd_bit: 1'b0, wunit: '0};
        end else begin
            q <= d;
        end
    end

    assign m_req   = (q.state == ST_RD) || (q.state == ST_WR);
    assign m_we    = (q.state == ST_WR);
    assign m_lock  = q.we && m_req;
    assign m_addr  = q.tgt;
    assign m_size  = q.size;
    assign m_wdata = q.wunit;
    assign s_ready = (q.state == ST_RESP);
    assign s_err   = (q.state == ST_ERR);
    assign s_rdata = {31'b0, q.rd_bit};
endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        s_ready,
    input logic        s_err,
    input logic [31:0] s_rdata,
    input logic        m_req,
    input logic        m_we,
    input logic        m_lock,
    input logic        m_ready,
    input logic [31:0] m_addr
);
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we)));

    assert_ready_after_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> $past(m_ready));

    assert_err_no_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_err |-> (!m_req && !$past(m_req)));

    assert_lock_spans_rmw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_lock && m_req && m_ready && !m_we) |=> (m_lock && m_req && m_we));

    assert_resp_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_ready, s_err}));

    assert_rdata_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (s_rdata[31:1] == 31'b0));
endmodule

bind bitband_bridge bitband_bridge_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_ready (s_ready),
    .s_err   (s_err),
    .s_rdata (s_rdata),
    .m_req   (m_req),
    .m_we    (m_we),
    .m_lock  (m_lock),
    .m_ready (m_ready),
    .m_addr  (m_addr)
);

// File: tb/bitband_bridge_tb_top.sv
module bitband_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_req = 1'b0;
    logic        s_we = 1'b0;
    logic [31:0] s_addr = '0;
    logic [1:0]  s_size = '0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic        s_ready, s_err;
    logic        m_req, m_we, m_lock;
    logic [31:0] m_addr, m_wdata;
    logic [1:0]  m_size;
    logic        m_ready = 1'b0;
    logic [31:0] m_rdata = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0]  tmem [2][16];
    logic [7:0]  rmem [2][16];
    int          beats = 0;
    int          lat_cnt = 0;
    logic [31:0] last_addr = '0;
    logic [1:0]  last_size = '0;
    logic        rd_lock = 1'b0;
    logic        wr_lock = 1'b0;
    logic        wdata_bad = 1'b0;

    localparam logic [31:0] ALIAS [2] = '{32'h2200_0000, 32'h4200_0000};
    localparam logic [31:0] TBASE [2] = '{32'h2000_0000, 32'h4000_0000};

    always #5 clk = ~clk;

    bitband_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
        .s_size(s_size), .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ready(s_ready),
        .s_err(s_err), .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size),
        .m_wdata(m_wdata), .m_lock(m_lock), .m_ready(m_ready), .m_rdata(m_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // target memory model: one beat per request, variable latency, garbage above unit width
    initial begin
        forever begin
            @(negedge clk);
            if (m_ready) begin
                m_ready = 1'b0;
            end else if (m_req) begin
                if (lat_cnt < (beats % 3)) begin
                    lat_cnt++;
                end else begin
                    int w;
                    int nb;
                    logic [31:0] v;
                    lat_cnt = 0;
                    w  = m_addr[30] ? 1 : 0;
                    nb = 1 << m_size;
                    last_addr = m_addr;
                    last_size = m_size;
                    if (m_we) begin
                        wr_lock = m_lock;
                        for (int k = 0; k < 4; k++) begin
                            if (k < nb) tmem[w][(m_addr[3:0] + k) & 15] = m_wdata[8*k +: 8];
                            else if (m_wdata[8*k +: 8] != 8'h00) wdata_bad = 1'b1;
                        end
                        m_rdata = '0;
                    end else begin
                        rd_lock = m_lock;
                        v = 32'hA5A5_A5A5;
                        for (int k = 0; k < nb; k++) v[8*k +: 8] = tmem[w][(m_addr[3:0] + k) & 15];
                        m_rdata = v;
                    end
                    beats++;
                    m_ready = 1'b1;
                end
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] a, input logic [1:0] sz, input bit wd,
                          output logic [31:0] rd, output bit err, output bit rdy);
        @(negedge clk);
        s_req = 1'b1; s_we = we; s_addr = a; s_size = sz; s_wdata = {31'h5555_5555, wd};
        do @(negedge clk); while (!(s_ready || s_err));
        rd = s_rdata; err = s_err; rdy = s_ready;
        s_req = 1'b0;
    endtask

    // expected target byte address and bit from the alias offset
    function automatic logic [31:0] tgt_byte(input logic [31:0] off, input int sz);
        logic [31:0] al;
        int idx;
        al  = (off & 32'h01FF_FFFF) >> 5;
        al  = al & ~((32'd1 << sz) - 1);
        idx = int'((off >> 2) & ((32'd8 << sz) - 1));
        return al + 32'(idx / 8);
    endfunction

    function automatic int tgt_bit(input logic [31:0] off, input int sz);
        return int'((off >> 2) & ((32'd8 << sz) - 1)) % 8;
    endfunction

    task automatic bit_test(input int w, input logic [31:0] off, input int sz);
        logic [31:0] rd, exp_addr, tb;
        bit err, rdy, exp_bit, nv;
        int b0, tbit;
        tb = tgt_byte(off, sz);
        tbit = tgt_bit(off, sz);
        exp_addr = TBASE[w] | (((off & 32'h01FF_FFFF) >> 5) & ~((32'd1 << sz) - 1));
        exp_bit = rmem[w][tb[3:0]][tbit];
        b0 = beats;
        access(1'b0, ALIAS[w] + off, 2'(sz), 1'b0, rd, err, rdy);
        check(rdy && !err, "R7 read ready", {30'b0, err, rdy}, 32'd1);
        check(rd == {31'b0, exp_bit}, "R3/R4 read bit", rd, {31'b0, exp_bit});
        check(last_addr == exp_addr && last_size == 2'(sz), "R1/R2 master addr", last_addr, exp_addr);
        check(beats == b0 + 1 && !rd_lock, "R6 read single unlocked beat", beats - b0, 32'd1);
        nv = ~exp_bit;
        b0 = beats;
        access(1'b1, ALIAS[w] + off, 2'(sz), nv, rd, err, rdy);
        rmem[w][tb[3:0]][tbit] = nv;
        check(rdy && !err, "R7 write ready", {30'b0, err, rdy}, 32'd1);
        check(beats == b0 + 2 && rd_lock && wr_lock, "R6 locked two beats", beats - b0, 32'd2);
        for (int k = 0; k < 16; k++)
            check(tmem[w][k] == rmem[w][k], "R5 target unit after write", {24'b0, tmem[w][k]}, {24'b0, rmem[w][k]});
    endtask

    task automatic miss_test(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] rd;
        bit err, rdy;
        int b0;
        b0 = beats;
        access(1'b1, a, sz, 1'b1, rd, err, rdy);
        check(err && !rdy && beats == b0, "R8 unclaimed request", a, 32'hE);
    endtask

    initial begin
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 16; i++) begin
                tmem[w][i] = 8'((i * 37 + w * 91 + 5) & 255);
                rmem[w][i] = tmem[w][i];
            end
        repeat (3) @(negedge clk);
        check(!s_ready && !s_err && !m_req && !m_lock, "R9 reset outputs",
              {28'b0, s_ready, s_err, m_req, m_lock}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!s_ready && !s_err && !m_req && !m_lock, "R9 idle after reset",
              {28'b0, s_ready, s_err, m_req, m_lock}, 32'd0);
        for (int w = 0; w < 2; w++)
            for (int sz = 0; sz < 3; sz++)
                for (int u = 0; u < 3; u++)
                    for (int n = 0; n < (8 << sz); n++)
                        bit_test(w, 32'(u * 4 * 32 + n * 4), sz);
        // unaligned unit addresses: R2 alignment, R3 index from the raw offset
        bit_test(0, 32'd172, 2);
        bit_test(1, 32'd172, 1);
        bit_test(0, 32'd172, 0);
        bit_test(1, 32'h0000_01E4, 1);
        // top of the window: R1 uses offset bits [24:5]
        bit_test(0, 32'h01FF_FFFC, 2);
        bit_test(1, 32'h01FF_FFE0, 0);
        miss_test(32'h21FF_FFFC, 2'd2);
        miss_test(32'h2400_0000, 2'd0);
        miss_test(32'h4400_0004, 2'd1);
        miss_test(32'h0000_0000, 2'd2);
        miss_test(32'h2200_0000, 2'd3);
        check(!wdata_bad, "R5 master write data upper bits zero", {31'b0, wdata_bad}, 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R7 no response actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule